// File: doc/BRIEF.md
# Header-Mode Register List Processor

This block runs register-programming lists that software has laid out in memory. Software writes the address of a header into the block's header-address input, which starts the run. The block reads the header word by word through a simple one-word read port and then walks its bodies. A body is a run of 8-byte entries, each an address word followed by a data word, and every entry becomes one write on the register-write output.

A header can name up to eight bodies, and they are executed in the order they are listed. Its flags word decides what happens once the last body is done. With the auto-start flag set, the block fetches another header from the next-header address without any help from the CPU, so a whole chain of headers runs back to back. With only the interrupt-enable flag set, the block raises a sticky completion interrupt and returns to idle. A chain therefore gives one interrupt, after its final header.

Header layout (32-bit words, byte offsets from the header address): word 0 at +0 is the extra-body count. Words 1 to 16 are eight pairs, each a body byte size followed by a body address, with slot k at +4+8k and +8+8k. Word 17 at +68 is the next-header address and word 18 at +72 is the flags word.

Top module: `reglist_engine`

## Requirements
- R1: A start pulse while idle latches start_addr and reads the 19 header words in index order from start_addr, start_addr+4, … start_addr+72.
- R2: A start pulse that arrives while busy is high is ignored: it changes neither the writes issued nor the addresses read.
- R3: Body 0 is always processed. The count word N selects bodies 0 to N. Any N above 7 is treated as 7.
- R4: Each entry occupies 8 bytes, with the register address at +0 and the data at +4, and entries follow one another at +8. Each entry gives exactly one cycle of wr_valid carrying that address and data.
- R5: A body's entry count is its byte size shifted right by 3, so the low three bits are ignored, and it is capped at MAX_ENTRIES. A body of size 0 to 7 issues no writes.
- R6: Bodies are executed strictly in slot order 0, 1, 2, and so on, and writes appear in entry order within each body.
- R7: When flags bit 0 (auto-start) is set, the block fetches the header at the next-header address after finishing the current one and raises no interrupt, even if bit 1 is also set.
- R8: When flags bit 0 is clear and bit 1 (interrupt-enable) is set, irq is set as the block goes idle. When both bits are clear, the block goes idle and irq stays low.
- R9: irq stays set until an irq_clear pulse. busy is high from the cycle after an accepted start until the last header completes.
- R10: The memory port carries one outstanding read at a time. mem_req is a single-cycle pulse, and it is raised only while the block is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Header-address register write; starts a run when idle |
| start_addr | input | W | Byte address of the first header |
| irq_clear | input | 1 | Write-one-to-clear for the completion interrupt |
| busy | output | 1 | High while a list chain is being processed |
| irq | output | 1 | Sticky completion interrupt |
| mem_req | output | 1 | Single-cycle word read request |
| mem_addr | output | W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data word |
| wr_valid | output | 1 | Register-write strobe |
| wr_addr | output | W | Register address of the write |
| wr_data | output | W | Register data of the write |

## Verification
The bench builds the block with MAX_ENTRIES set to 16, so a body of 20 entries exercises the cap without long runs. The header keeps its full eight-slot format, so the count clamp, empty slots and sizes that are not a multiple of 8 all fall within one header. Every scenario is repeated with memory read latencies of 1, 2 and 3 cycles. The bench predicts the write stream, the read count and the interrupt from its own copy of memory.

// File: rtl/rle_pkg.sv
// Package: shared constants and sequencer state for the register list processor.
// Assumes the header format has eight body slots; flag bit positions are fixed.
package rle_pkg;
    localparam int HDR_BODY_SLOTS = 8;
    localparam int ENTRY_SHIFT    = 3;   // 8 bytes per entry
    localparam int FLAG_AUTO      = 0;
    localparam int FLAG_IRQ       = 1;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HREQ, ST_HWAIT, ST_BSEL,
        ST_AREQ, ST_AWAIT, ST_DREQ, ST_DWAIT, ST_END
    } seq_state_t;
endpackage

// File: rtl/rle_hdr_regs.sv
// Header register file: captures header words by index while they are fetched.
// Stores each body's entry count already rounded down and capped, and its address.
// Assumes cap_idx counts 0..HDR_WORDS-1 in header word order.
module rle_hdr_regs
    import rle_pkg::*;
#(
    parameter int W           = 32,
    parameter int NBODY       = HDR_BODY_SLOTS,
    parameter int MAX_ENTRIES = 256,
    localparam int HDR_WORDS  = 3 + 2 * NBODY,
    localparam int IW         = $clog2(HDR_WORDS),
    localparam int BW         = $clog2(NBODY),
    localparam int EW         = $clog2(MAX_ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [IW-1:0] cap_idx,
    input  logic [W-1:0]  cap_word,
    input  logic [BW-1:0] sel_body,
    output logic [BW-1:0] last_body,
    output logic [EW-1:0] sel_entries,
    output logic [W-1:0]  sel_addr,
    output logic [W-1:0]  next_addr,
    output logic          auto_start,
    output logic          irq_enable
);
    logic [EW-1:0] ent_q  [NBODY];
    logic [W-1:0]  addr_q [NBODY];
    logic [W-4:0]  word_raw;
    logic [EW-1:0] word_ent;
    logic [BW-1:0] word_last;

    // Convert a captured word into a capped entry count and a clamped body index.
    always_comb begin
        word_raw  = cap_word[W-1:ENTRY_SHIFT];
        word_ent  = (word_raw > (W-3)'(MAX_ENTRIES)) ? EW'(MAX_ENTRIES) : word_raw[EW-1:0];
        word_last = (cap_word > W'(NBODY - 1)) ? BW'(NBODY - 1) : cap_word[BW-1:0];
    end

    // Capture per-body size and address words into their slots.
    always_ff @(posedge clk) begin
        for (int b = 0; b < NBODY; b++) begin
            if (!rst_n) begin
                ent_q[b]  <= '0;
                addr_q[b] <= '0;
            end else if (cap_en && cap_idx == IW'(1 + 2 * b)) begin
                ent_q[b]  <= word_ent;
            end else if (cap_en && cap_idx == IW'(2 + 2 * b)) begin
                addr_q[b] <= cap_word;
            end
        end
    end

    // Capture the count, next-header and flags words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_body  <= '0;
            next_addr  <= '0;
            auto_start <= 1'b0;
            irq_enable <= 1'b0;
        end else if (cap_en) begin
            if (cap_idx == '0)
                last_body <= word_last;
            if (cap_idx == IW'(HDR_WORDS - 2))
                next_addr <= cap_word;
            if (cap_idx == IW'(HDR_WORDS - 1)) begin
                auto_start <= cap_word[FLAG_AUTO];
                irq_enable <= cap_word[FLAG_IRQ];
            end
        end
    end

    assign sel_entries = ent_q[sel_body];
    assign sel_addr    = addr_q[sel_body];
endmodule

// File: rtl/rle_irq_status.sv
// Sticky completion interrupt: set by a completion pulse, cleared by write-one-to-clear.
// Assumes a set and a clear in the same cycle resolve to set.
module rle_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clr_pulse,
    output logic irq
);
    // Hold the interrupt until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (set_pulse) irq <= 1'b1;
        else if (clr_pulse) irq <= 1'b0;
    end
endmodule

// File: rtl/rle_seq.sv
// Sequencer: fetches headers, walks bodies and entries, issues register writes
// and follows auto-start chains. Assumes one outstanding memory read; the
// response may arrive any number of cycles (at least one) after the request.
module rle_seq
    import rle_pkg::*;
#(
    parameter int W           = 32,
    parameter int NBODY       = HDR_BODY_SLOTS,
    parameter int MAX_ENTRIES = 256,
    localparam int HDR_WORDS  = 3 + 2 * NBODY,
    localparam int IW         = $clog2(HDR_WORDS),
    localparam int BW         = $clog2(NBODY),
    localparam int EW         = $clog2(MAX_ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_valid,
    input  logic [W-1:0]  start_addr,
    output logic          mem_req,
    output logic [W-1:0]  mem_addr,
    input  logic          mem_rvalid,
    input  logic [W-1:0]  mem_rdata,
    output logic          cap_en,
    output logic [IW-1:0] cap_idx,
    output logic [BW-1:0] sel_body,
    input  logic [BW-1:0] last_body,
    input  logic [EW-1:0] sel_entries,
    input  logic [W-1:0]  sel_addr,
    input  logic [W-1:0]  next_addr,
    input  logic          auto_start,
    input  logic          irq_enable,
    output logic          wr_valid,
    output logic [W-1:0]  wr_addr,
    output logic [W-1:0]  wr_data,
    output logic          done_irq,
    output logic          busy
);
    localparam logic [IW-1:0] LAST_WIDX = IW'(HDR_WORDS - 1);

    seq_state_t    state;
    logic [W-1:0]  hdr_base, eptr, areg;
    logic [IW-1:0] widx;
    logic [BW:0]   bidx;
    logic [EW-1:0] remain;
    logic          body_over;

    assign body_over = bidx > {1'b0, last_body};

    // Walk header words, bodies and entries; emit one write per entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hdr_base <= '0;
            eptr     <= '0;
            areg     <= '0;
            widx     <= '0;
            bidx     <= '0;
            remain   <= '0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            case (state)
                ST_IDLE: if (start_valid) begin
                    hdr_base <= start_addr;
                    widx     <= '0;
                    state    <= ST_HREQ;
                end
                ST_HREQ:  state <= ST_HWAIT;
                ST_HWAIT: if (mem_rvalid) begin
                    if (widx == LAST_WIDX) begin
                        bidx  <= '0;
                        state <= ST_BSEL;
                    end else begin
                        widx  <= widx + 1'b1;
                        state <= ST_HREQ;
                    end
                end
                ST_BSEL: begin
                    if (body_over) begin
                        state <= ST_END;
                    end else if (sel_entries == '0) begin
                        bidx <= bidx + 1'b1;
                    end else begin
                        eptr   <= sel_addr;
                        remain <= sel_entries;
                        state  <= ST_AREQ;
                    end
                end
                ST_AREQ:  state <= ST_AWAIT;
                ST_AWAIT: if (mem_rvalid) begin
                    areg  <= mem_rdata;
                    state <= ST_DREQ;
                end
                ST_DREQ:  state <= ST_DWAIT;
                ST_DWAIT: if (mem_rvalid) begin
                    wr_valid <= 1'b1;
                    wr_addr  <= areg;
                    wr_data  <= mem_rdata;
                    eptr     <= eptr + W'(8);
                    remain   <= remain - 1'b1;
                    if (remain == EW'(1)) begin
                        bidx  <= bidx + 1'b1;
                        state <= ST_BSEL;
                    end else begin
                        state <= ST_AREQ;
                    end
                end
                ST_END: begin
                    if (auto_start) begin
                        hdr_base <= next_addr;
                        widx     <= '0;
                        state    <= ST_HREQ;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the read port address for the current fetch.
    always_comb begin
        mem_req  = (state == ST_HREQ) || (state == ST_AREQ) || (state == ST_DREQ);
        mem_addr = eptr;
        if (state == ST_HREQ)      mem_addr = hdr_base + W'({widx, 2'b00});
        else if (state == ST_DREQ) mem_addr = eptr + W'(4);
    end

    assign cap_en   = (state == ST_HWAIT) && mem_rvalid;
    assign cap_idx  = widx;
    assign sel_body = bidx[BW-1:0];
    assign done_irq = (state == ST_END) && !auto_start && irq_enable;
    assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/reglist_engine.sv
// Top: header-mode register list processor. Connects the sequencer, the
// header register file and the sticky interrupt. Assumes software only
// starts it while idle; starts during a run are dropped.
module reglist_engine
    import rle_pkg::*;
#(
    parameter int W           = 32,
    parameter int MAX_ENTRIES = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_valid,
    input  logic [W-1:0] start_addr,
    input  logic         irq_clear,
    output logic         busy,
    output logic         irq,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    input  logic         mem_rvalid,
    input  logic [W-1:0] mem_rdata,
    output logic         wr_valid,
    output logic [W-1:0] wr_addr,
    output logic [W-1:0] wr_data
);
    localparam int NBODY     = HDR_BODY_SLOTS;
    localparam int HDR_WORDS = 3 + 2 * NBODY;
    localparam int IW        = $clog2(HDR_WORDS);
    localparam int BW        = $clog2(NBODY);
    localparam int EW        = $clog2(MAX_ENTRIES + 1);

    logic          cap_en, auto_start, irq_enable, done_irq;
    logic [IW-1:0] cap_idx;
    logic [BW-1:0] sel_body, last_body;
    logic [EW-1:0] sel_entries;
    logic [W-1:0]  sel_addr, next_addr;

    rle_seq #(.W(W), .NBODY(NBODY), .MAX_ENTRIES(MAX_ENTRIES)) i_seq (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_addr(start_addr),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cap_en(cap_en), .cap_idx(cap_idx), .sel_body(sel_body),
        .last_body(last_body), .sel_entries(sel_entries), .sel_addr(sel_addr),
        .next_addr(next_addr), .auto_start(auto_start), .irq_enable(irq_enable),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .done_irq(done_irq), .busy(busy)
    );

    rle_hdr_regs #(.W(W), .NBODY(NBODY), .MAX_ENTRIES(MAX_ENTRIES)) i_hdr (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_idx(cap_idx), .cap_word(mem_rdata),
        .sel_body(sel_body), .last_body(last_body), .sel_entries(sel_entries),
        .sel_addr(sel_addr), .next_addr(next_addr),
        .auto_start(auto_start), .irq_enable(irq_enable)
    );

    rle_irq_status i_irq (
        .clk(clk), .rst_n(rst_n),
        .set_pulse(done_irq), .clr_pulse(irq_clear), .irq(irq)
    );
endmodule

// File: rtl/rle_checker.sv
// Checker: port-level protocol and interrupt properties of reglist_engine.
module rle_checker (
    input logic clk,
    input logic rst_n,
    input logic start_valid,
    input logic irq_clear,
    input logic busy,
    input logic irq,
    input logic mem_req,
    input logic wr_valid
);
    // R10: a request lasts one cycle, so only one read is ever outstanding
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R10: no memory traffic while idle
    p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R1: an accepted start makes the block busy
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && !busy |=> busy);
    // R9: interrupt is sticky
    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clear |=> irq);
    // R9: clear while idle drops the interrupt
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear && !busy |=> !irq);
    // R8: interrupt only rises as the block returns to idle
    p_irq_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(busy) && !busy);
    // R4: register writes only during a run
    p_wr_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);
endmodule

bind reglist_engine rle_checker i_chk (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .irq_clear(irq_clear),
    .busy(busy), .irq(irq), .mem_req(mem_req), .wr_valid(wr_valid)
);

// File: tb/test_reglist_engine.sv
module test_reglist_engine;
    localparam int CLK_PERIOD = 10;
    localparam int MAXE       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic [31:0] start_addr = '0;
    logic        irq_clear = 1'b0;
    logic        busy, irq, mem_req, wr_valid;
    logic [31:0] mem_addr, wr_addr, wr_data;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    logic [31:0] mem [4096];
    logic [31:0] exp_a [$];
    logic [31:0] exp_d [$];
    int reads = 0;
    int lat_cfg = 1;
    int early_irq = 0;
    logic [31:0] last_first = '0;
    bit want_first = 0;

    reglist_engine #(.W(32), .MAX_ENTRIES(MAXE)) i_reglist_engine (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
        .irq_clear(irq_clear), .busy(busy), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model with configurable response latency.
    logic        pend = 1'b0;
    logic [31:0] paddr = '0;
    int          pcnt = 0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (mem_req) begin
            pend  <= 1'b1;
            paddr <= mem_addr;
            pcnt  <= lat_cfg;
            reads <= reads + 1;
            if (want_first) begin
                last_first <= mem_addr;
                want_first <= 1'b0;
            end
        end else if (pend) begin
            if (pcnt <= 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[paddr[13:2]];
                pend       <= 1'b0;
            end else begin
                pcnt <= pcnt - 1;
            end
        end
    end

    // Write monitor: every write must match the predicted stream (R4, R6).
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_a.size() == 0) begin
                chk(0, "R4", "unexpected write addr", wr_addr, 0);
            end else begin
                chk(wr_addr == exp_a[0] && wr_data == exp_d[0], "R6",
                    "write addr/data order", {wr_addr, wr_data}, {exp_a[0], exp_d[0]});
                void'(exp_a.pop_front());
                void'(exp_d.pop_front());
            end
        end
        if (rst_n && busy && irq) early_irq++;
    end

    function automatic int w(input int a);
        return (a >> 2) & 4095;
    endfunction

    // Header builder: clears all slots, sets count, next and flags.
    task automatic put_hdr(input int base, input int cnt, input int nxt, input int flags);
        mem[w(base)] = cnt;
        for (int b = 0; b < 8; b++) begin
            mem[w(base) + 1 + 2 * b] = 0;
            mem[w(base) + 2 + 2 * b] = 0;
        end
        mem[w(base) + 17] = nxt;
        mem[w(base) + 18] = flags;
    endtask

    // Body builder: sets the slot and fills entries with distinct values.
    task automatic put_body(input int base, input int slot, input int baddr, input int size);
        mem[w(base) + 1 + 2 * slot] = size;
        mem[w(base) + 2 + 2 * slot] = baddr;
        for (int i = 0; i < (size >> 3); i++) begin
            mem[w(baddr) + 2 * i]     = 32'hA000_0000 + baddr + i * 4;
            mem[w(baddr) + 2 * i + 1] = 32'h5000_0000 + (baddr << 4) + i * 7 + lat_cfg;
        end
    endtask

    // Reference model: predicts writes, reads and the interrupt from the bench memory.
    task automatic model(input int base, output int nrd, output bit irq_exp);
        int h = base;
        int hdrs = 0;
        nrd = 0;
        irq_exp = 0;
        while (hdrs < 16) begin
            int cnt = mem[w(h)];
            int fl;
            hdrs++;
            nrd += 19;
            if (cnt > 7) cnt = 7;
            for (int b = 0; b <= cnt; b++) begin
                int n = mem[w(h) + 1 + 2 * b] >> 3;
                int ba = mem[w(h) + 2 + 2 * b];
                if (n > MAXE) n = MAXE;
                for (int i = 0; i < n; i++) begin
                    exp_a.push_back(mem[w(ba) + 2 * i]);
                    exp_d.push_back(mem[w(ba) + 2 * i + 1]);
                    nrd += 2;
                end
            end
            fl = mem[w(h) + 18];
            if (fl[0]) h = mem[w(h) + 17];
            else begin
                irq_exp = fl[1];
                break;
            end
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk) irq_clear = 1'b1;
        @(negedge clk) irq_clear = 1'b0;
    endtask

    // Runs one list chain and checks its outcome.
    task automatic run(input int base, input string tag, input bit poke);
        int nrd, r0, waited;
        bit irq_exp;
        model(base, nrd, irq_exp);
        pulse_clear();
        early_irq = 0;
        r0 = reads;
        want_first = 1;
        @(negedge clk);
        start_valid = 1'b1;
        start_addr  = base;
        @(negedge clk);
        start_valid = 1'b0;
        chk(busy == 1'b1, "R9", {tag, " busy after start"}, busy, 1);
        if (poke) begin
            repeat (10) @(negedge clk);
            start_valid = 1'b1;
            start_addr  = 32'h200;
            @(negedge clk);
            start_valid = 1'b0;
        end
        waited = 0;
        while (busy && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        repeat (2) @(negedge clk);
        chk(!busy, "R9", {tag, " idle at end"}, busy, 0);
        chk(exp_a.size() == 0, poke ? "R2" : "R6", {tag, " writes left"}, exp_a.size(), 0);
        chk(reads - r0 == nrd, poke ? "R2" : "R10", {tag, " read count"}, reads - r0, nrd);
        chk(last_first == base, "R1", {tag, " first header address"}, last_first, base);
        chk(irq == irq_exp, irq_exp ? "R8" : "R7", {tag, " irq at end"}, irq, irq_exp);
        chk(early_irq == 0, "R7", {tag, " irq during chain"}, early_irq, 0);
        exp_a.delete();
        exp_d.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && irq == 0 && wr_valid == 0 && mem_req == 0, "R9",
            "reset state", {busy, irq, wr_valid, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int lat = 1; lat <= 3; lat++) begin
            lat_cfg = lat;
            // A: one body, R3 count 0, R8 interrupt
            put_hdr(32'h000, 0, 0, 2);
            put_body(32'h000, 0, 32'h1000, 24);
            put_body(32'h000, 1, 32'h1200, 16);    // must be skipped (count 0), R3
            run(32'h000, "R3 single body", 0);

            // B: all slots, zero sizes, odd sizes, R5/R6
            put_hdr(32'h100, 7, 0, 2);
            put_body(32'h100, 0, 32'h1400, 16);
            put_body(32'h100, 1, 32'h1600, 0);
            put_body(32'h100, 2, 32'h1800, 13);
            put_body(32'h100, 3, 32'h1A00, 8);
            put_body(32'h100, 4, 32'h1C00, 40);
            put_body(32'h100, 5, 32'h1E00, 7);
            put_body(32'h100, 6, 32'h2000, 7);
            put_body(32'h100, 7, 32'h2200, 24);
            run(32'h100, "R5 mixed sizes", 0);

            // C: count above 7 clamps, no flags -> no interrupt (R3, R8)
            put_hdr(32'h200, 9, 0, 0);
            for (int b = 0; b < 8; b++) put_body(32'h200, b, 32'h2400 + b * 32'h100, 8);
            run(32'h200, "R3 count clamp", 0);

            // D: chain of three; cap at MAXE; auto-start with irq bit set (R7, R5)
            put_hdr(32'h300, 1, 32'h400, 3);
            put_body(32'h300, 0, 32'h3000, 160);
            put_body(32'h300, 1, 32'h3200, 8);
            put_hdr(32'h400, 0, 32'h500, 1);
            put_body(32'h400, 0, 32'h3400, 24);
            put_hdr(32'h500, 0, 0, 2);
            put_body(32'h500, 0, 32'h3600, 16);
            run(32'h300, "R7 chain", 0);

            // E: start while busy is ignored (R2)
            run(32'h000, "R2 busy start", 1);
        end

        // F: sticky interrupt and clear (R9)
        repeat (30) @(negedge clk);
        chk(irq == 1'b1, "R9", "irq held", irq, 1);
        @(negedge clk) irq_clear = 1'b1;
        @(negedge clk) irq_clear = 1'b0;
        chk(irq == 1'b0, "R9", "irq cleared", irq, 0);
        repeat (5) @(negedge clk);
        chk(irq == 1'b0 && !busy && !mem_req, "R10", "idle quiet", {irq, busy, mem_req}, 0);

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule